// File: doc/BRIEF.md
# DMA Interrupt Status and Mask Unit

This unit collects completion events from the transmit and receive channels of a DMA engine, along with a host-error event. It holds them in raw status registers and qualifies them with software-controlled enables. The results form three event groups: transmit, receive and DMA. Each group can be read as a raw view and as a masked view. A single combined interrupt line goes to the processor.

Software never writes an enable register directly. It enables bits through a write-one-to-set register and disables them through a separate write-one-to-clear register. A channel's raw bit stays set after its completion event until software acknowledges that channel's completion pointer. A write to the end-of-interrupt register lowers the interrupt line for one clock. The line then rises again if anything is still pending, so a level-sensitive receiver sees a fresh edge. All registers sit at byte offsets from the DMA register base. Reads are combinational on the address.

Top module: `dma_irq_unit`

## Requirements
- R1: After a synchronous active-low reset, every raw status bit and every enable bit is 0, and `irq` is low.
- R2: Writing to the set register of a group (transmit 0x88, receive 0xA8, DMA 0xB8) turns on the enable bits written as 1. Writing to the clear register (0x8C, 0xAC, 0xBC) turns those bits off. Bits written as 0 leave the enables unchanged. Reading either register returns the current enables.
- R3: A one-cycle pulse on bit n of `tx_done` or `rx_done` sets raw bit n of that group, read at 0x80 or 0xA0. The bit stays set until a pulse on bit n of `tx_ack` or `rx_ack`. If an event and an acknowledge arrive in the same cycle, the bit ends up set.
- R4: The masked views (0x84, 0xA4, 0xB4) read as raw AND enable. The raw views always read the raw bits, whatever the enables are.
- R5: `irq` is a registered signal. One clock after any masked bit of any group is set, `irq` is high. One clock after no masked bit is set, `irq` is low.
- R6: A write to 0x94 drives `irq` low in the following cycle. In the cycle after that, `irq` rises again if a masked bit is still set.
- R7: A pulse on `host_err` sets bit 1 of the DMA group raw view (0xB0). Writing 1 to bit 1 at 0xB0 clears it. Bit 0 of the DMA group, both raw and enable, always reads 0.
- R8: Writing all ones to a clear register disables every channel of that group. Bits at positions NCH and above read 0 in every view. Unmapped offsets read 0, and writes to them have no effect.
- R9: Writes to the transmit or receive raw views (0x80, 0xA0) do not change any raw bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Register byte offset |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` (combinational) |
| tx_done | input | NCH | Transmit completion pulses, bit n = channel n |
| rx_done | input | NCH | Receive completion pulses, bit n = channel n |
| tx_ack | input | NCH | Transmit completion-pointer acknowledge pulses |
| rx_ack | input | NCH | Receive completion-pointer acknowledge pulses |
| host_err | input | 1 | Host-error event pulse |
| irq | output | 1 | Combined interrupt |

## Verification
The assertions assume that every register access is a single-cycle strobe, so a set write and a clear write to the same group never share a cycle. They also assume that event and acknowledge inputs are one-cycle pulses, driven away from the clock edge. The stimulus holds each write and each pulse for exactly one cycle and drops it before the next step. The only time an event and an acknowledge overlap on the same channel is in the directed priority case, where the bench checks the resulting raw bit at the ports.

// File: rtl/dma_irq_pkg.sv
// Package: register offsets and widths shared by the interrupt unit.
// Assumes a 32-bit register data path and byte-addressed 8-bit offsets.
package dma_irq_pkg;
    localparam int DW = 32;
    localparam int AW = 8;

    localparam logic [AW-1:0] OFF_TX_RAW  = 8'h80;
    localparam logic [AW-1:0] OFF_TX_MSK  = 8'h84;
    localparam logic [AW-1:0] OFF_TX_SET  = 8'h88;
    localparam logic [AW-1:0] OFF_TX_CLR  = 8'h8C;
    localparam logic [AW-1:0] OFF_EOI     = 8'h94;
    localparam logic [AW-1:0] OFF_RX_RAW  = 8'hA0;
    localparam logic [AW-1:0] OFF_RX_MSK  = 8'hA4;
    localparam logic [AW-1:0] OFF_RX_SET  = 8'hA8;
    localparam logic [AW-1:0] OFF_RX_CLR  = 8'hAC;
    localparam logic [AW-1:0] OFF_DM_RAW  = 8'hB0;
    localparam logic [AW-1:0] OFF_DM_MSK  = 8'hB4;
    localparam logic [AW-1:0] OFF_DM_SET  = 8'hB8;
    localparam logic [AW-1:0] OFF_DM_CLR  = 8'hBC;

    // DMA group: bit 1 is the host-error source, bit 0 is not implemented
    localparam int DM_W = 2;
    localparam logic [DM_W-1:0] DM_IMPL = 2'b10;
endpackage

// File: rtl/dma_irq_group.sv
// Module: one event group: raw sticky status plus set/clear enable mask.
// Assumes set_ev/clr_ev are single-cycle pulses and that mask_set_we and
// mask_clr_we are never high together. Event wins over clear in one cycle.
module dma_irq_group #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_ev,
    input  logic [W-1:0] clr_ev,
    input  logic         mask_set_we,
    input  logic         mask_clr_we,
    input  logic [W-1:0] wbits,
    output logic [W-1:0] raw,
    output logic [W-1:0] mask,
    output logic [W-1:0] masked
);

    // Raw status: sticky until acknowledged, new events take priority
    always_ff @(posedge clk) begin
        if (!rst_n) raw <= '0;
        else        raw <= (raw & ~clr_ev) | set_ev;
    end

    // Enable mask: modified only through write-one-to-set / write-one-to-clear
    always_ff @(posedge clk) begin
        if (!rst_n)           mask <= '0;
        else if (mask_set_we) mask <= mask | wbits;
        else if (mask_clr_we) mask <= mask & ~wbits;
    end

    // Masked view
    always_comb masked = raw & mask;

    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (raw == '0 && mask == '0));

    a_r3_raw_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((($past(raw) & ~$past(clr_ev)) & ~raw) == '0));

    a_r3_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (set_ev != '0) |=> ((raw & $past(set_ev)) == $past(set_ev)));

    a_r2_set_enables: assert property (@(posedge clk) disable iff (!rst_n)
        mask_set_we |=> ((mask & $past(wbits)) == $past(wbits)));

    a_r2_clear_disables: assert property (@(posedge clk) disable iff (!rst_n)
        mask_clr_we |=> ((mask & $past(wbits)) == '0));

    a_r2_mask_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!mask_set_we && !mask_clr_we) |=> $stable(mask));

endmodule

// File: rtl/dma_irq_out.sv
// Module: combined interrupt register with end-of-interrupt re-arm.
// Assumes eoi_we is a single-cycle strobe. irq drops for one clock after
// each EOI and then follows the OR of masked status again.
module dma_irq_out (
    input  logic clk,
    input  logic rst_n,
    input  logic any_pending,
    input  logic eoi_we,
    output logic irq
);

    // Register the pending OR, forcing one low cycle after EOI
    always_ff @(posedge clk) begin
        if (!rst_n)      irq <= 1'b0;
        else if (eoi_we) irq <= 1'b0;
        else             irq <= any_pending;
    end

    a_r6_eoi_drop: assert property (@(posedge clk) disable iff (!rst_n)
        eoi_we |=> !irq);

    a_r5_rise_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(any_pending));

    a_r5_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        !any_pending |=> !irq);

endmodule

// File: rtl/dma_irq_unit.sv
// Module: DMA interrupt status and mask unit (top).
// Decodes the register port, hosts the transmit, receive and DMA groups,
// and drives one interrupt. Assumes NCH <= 8 and single-cycle write strobes.
module dma_irq_unit
    import dma_irq_pkg::*;
#(
    parameter int NCH = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    input  logic [NCH-1:0] tx_done,
    input  logic [NCH-1:0] rx_done,
    input  logic [NCH-1:0] tx_ack,
    input  logic [NCH-1:0] rx_ack,
    input  logic          host_err,
    output logic          irq
);

    localparam int PAD_CH = DW - NCH;
    localparam int PAD_DM = DW - DM_W;

    logic [NCH-1:0]  tx_raw, tx_mask, tx_msk;
    logic [NCH-1:0]  rx_raw, rx_mask, rx_msk;
    logic [DM_W-1:0] dm_raw, dm_mask, dm_msk;
    logic [DM_W-1:0] dm_wbits, dm_clr;
    logic            eoi_we;
    logic            any_pending;
    logic            unused_wdata;

    // Only implemented DMA bits may be touched by software
    always_comb dm_wbits = wdata[DM_W-1:0] & DM_IMPL;
    // Host error is acknowledged by write-one-to-clear on its raw view
    always_comb dm_clr   = (wr_en && addr == OFF_DM_RAW) ? dm_wbits : '0;
    // End-of-interrupt strobe
    always_comb eoi_we   = wr_en && addr == OFF_EOI;
    // Upper write-data bits have no destination
    always_comb unused_wdata = ^wdata;

    dma_irq_group #(.W(NCH)) u_tx (
        .clk(clk), .rst_n(rst_n),
        .set_ev(tx_done), .clr_ev(tx_ack),
        .mask_set_we(wr_en && addr == OFF_TX_SET),
        .mask_clr_we(wr_en && addr == OFF_TX_CLR),
        .wbits(wdata[NCH-1:0]),
        .raw(tx_raw), .mask(tx_mask), .masked(tx_msk)
    );

    dma_irq_group #(.W(NCH)) u_rx (
        .clk(clk), .rst_n(rst_n),
        .set_ev(rx_done), .clr_ev(rx_ack),
        .mask_set_we(wr_en && addr == OFF_RX_SET),
        .mask_clr_we(wr_en && addr == OFF_RX_CLR),
        .wbits(wdata[NCH-1:0]),
        .raw(rx_raw), .mask(rx_mask), .masked(rx_msk)
    );

    dma_irq_group #(.W(DM_W)) u_dm (
        .clk(clk), .rst_n(rst_n),
        .set_ev({host_err, 1'b0}), .clr_ev(dm_clr),
        .mask_set_we(wr_en && addr == OFF_DM_SET),
        .mask_clr_we(wr_en && addr == OFF_DM_CLR),
        .wbits(dm_wbits),
        .raw(dm_raw), .mask(dm_mask), .masked(dm_msk)
    );

    // Any masked source in any group requests an interrupt
    always_comb any_pending = (|tx_msk) | (|rx_msk) | (|dm_msk);

    dma_irq_out u_out (
        .clk(clk), .rst_n(rst_n),
        .any_pending(any_pending), .eoi_we(eoi_we), .irq(irq)
    );

    // Read mux: zero-extended views, unmapped offsets read zero
    always_comb begin
        case (addr)
            OFF_TX_RAW:             rdata = {{PAD_CH{1'b0}}, tx_raw};
            OFF_TX_MSK:             rdata = {{PAD_CH{1'b0}}, tx_msk};
            OFF_TX_SET, OFF_TX_CLR: rdata = {{PAD_CH{1'b0}}, tx_mask};
            OFF_RX_RAW:             rdata = {{PAD_CH{1'b0}}, rx_raw};
            OFF_RX_MSK:             rdata = {{PAD_CH{1'b0}}, rx_msk};
            OFF_RX_SET, OFF_RX_CLR: rdata = {{PAD_CH{1'b0}}, rx_mask};
            OFF_DM_RAW:             rdata = {{PAD_DM{1'b0}}, dm_raw};
            OFF_DM_MSK:             rdata = {{PAD_DM{1'b0}}, dm_msk};
            OFF_DM_SET, OFF_DM_CLR: rdata = {{PAD_DM{1'b0}}, dm_mask};
            default:                rdata = '0;
        endcase
    end

    a_r7_dm_bit0_zero: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (dm_raw[0] == 1'b0 && dm_mask[0] == 1'b0));

    a_r7_host_err_sets: assert property (@(posedge clk) disable iff (!rst_n)
        host_err |=> dm_raw[1]);

    a_r9_raw_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == OFF_TX_RAW && tx_done == '0 && tx_ack == '0)
        |=> $stable(tx_raw));

endmodule

// File: tb/tb_dma_irq_unit.sv
// Bench: vector table walked one step per clock, then directed cases.
module tb_dma_irq_unit;
    localparam int NCH = 8;
    localparam int NV  = 49;
    // kinds
    localparam logic [2:0] K_RD = 3'd0, K_WR = 3'd1, K_TXD = 3'd2, K_RXD = 3'd3,
                           K_TXA = 3'd4, K_RXA = 3'd5, K_HE = 3'd6, K_IRQ = 3'd7;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0;
    logic [7:0] addr = 8'h00;
    logic [31:0] wdata = 32'h0;
    logic [31:0] rdata;
    logic [NCH-1:0] tx_done = '0, rx_done = '0, tx_ack = '0, rx_ack = '0;
    logic host_err = 1'b0;
    logic irq;
    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    dma_irq_unit #(.NCH(NCH)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .tx_done(tx_done), .rx_done(rx_done), .tx_ack(tx_ack),
        .rx_ack(rx_ack), .host_err(host_err), .irq(irq)
    );

    // {kind[2:0], req[3:0], addr[7:0], data[31:0], expect[31:0]}
    typedef logic [78:0] vec_t;
    localparam vec_t VEC [NV] = '{
        {K_RD,  4'd1, 8'h80, 32'h0, 32'h0},        // R1 tx raw zero
        {K_RD,  4'd1, 8'h88, 32'h0, 32'h0},        // R1 tx enables zero
        {K_IRQ, 4'd1, 8'h00, 32'h0, 32'h0},        // R1 irq low
        {K_TXD, 4'd3, 8'h00, 32'h05, 32'h0},       // R3 ch0, ch2 done
        {K_RD,  4'd3, 8'h80, 32'h0, 32'h05},       // R3 raw bits set
        {K_RD,  4'd4, 8'h84, 32'h0, 32'h0},        // R4 masked empty
        {K_IRQ, 4'd5, 8'h00, 32'h0, 32'h0},        // R5 nothing enabled
        {K_WR,  4'd2, 8'h88, 32'h04, 32'h0},       // R2 enable ch2
        {K_RD,  4'd2, 8'h88, 32'h0, 32'h04},       // R2 enable readback
        {K_IRQ, 4'd5, 8'h00, 32'h0, 32'h1},        // R5 irq asserted
        {K_RD,  4'd4, 8'h84, 32'h0, 32'h04},       // R4 masked view
        {K_WR,  4'd9, 8'h80, 32'hFF, 32'h0},       // R9 write raw
        {K_RD,  4'd9, 8'h80, 32'h0, 32'h05},       // R9 raw unchanged
        {K_TXA, 4'd3, 8'h00, 32'h04, 32'h0},       // R3 ack ch2
        {K_RD,  4'd3, 8'h80, 32'h0, 32'h01},       // R3 only ch2 cleared
        {K_RD,  4'd4, 8'h84, 32'h0, 32'h0},        // R4 masked now empty
        {K_IRQ, 4'd5, 8'h00, 32'h0, 32'h0},        // R5 irq dropped
        {K_RXD, 4'd3, 8'h00, 32'h80, 32'h0},       // R3 rx ch7 done
        {K_WR,  4'd2, 8'hA8, 32'h0, 32'h0},        // R2 zero write
        {K_RD,  4'd2, 8'hAC, 32'h0, 32'h0},        // R2 no effect
        {K_WR,  4'd2, 8'hA8, 32'h81, 32'h0},       // R2 enable ch0, ch7
        {K_RD,  4'd4, 8'hA4, 32'h0, 32'h80},       // R4 rx masked
        {K_WR,  4'd2, 8'hAC, 32'h01, 32'h0},       // R2 clear ch0 only
        {K_RD,  4'd2, 8'hA8, 32'h0, 32'h80},       // R2 ch7 still enabled
        {K_IRQ, 4'd5, 8'h00, 32'h0, 32'h1},        // R5 rx drives irq
        {K_WR,  4'd6, 8'h94, 32'h0, 32'h0},        // R6 EOI
        {K_IRQ, 4'd6, 8'h00, 32'h0, 32'h0},        // R6 one low cycle
        {K_IRQ, 4'd6, 8'h00, 32'h0, 32'h1},        // R6 re-asserts
        {K_WR,  4'd8, 8'hAC, 32'hFFFFFFFF, 32'h0}, // R8 disable all rx
        {K_WR,  4'd8, 8'h8C, 32'hFFFFFFFF, 32'h0}, // R8 disable all tx
        {K_RD,  4'd8, 8'hA8, 32'h0, 32'h0},        // R8 rx enables zero
        {K_RD,  4'd8, 8'h88, 32'h0, 32'h0},        // R8 tx enables zero
        {K_IRQ, 4'd8, 8'h00, 32'h0, 32'h0},        // R8 irq low
        {K_HE,  4'd7, 8'h00, 32'h0, 32'h0},        // R7 host error
        {K_RD,  4'd7, 8'hB0, 32'h0, 32'h02},       // R7 bit 1
        {K_WR,  4'd7, 8'hB8, 32'hFFFFFFFF, 32'h0}, // R7 enable DMA group
        {K_RD,  4'd7, 8'hBC, 32'h0, 32'h02},       // R7 bit0 reads zero
        {K_RD,  4'd4, 8'hB4, 32'h0, 32'h02},       // R4 dma masked
        {K_IRQ, 4'd5, 8'h00, 32'h0, 32'h1},        // R5 host err irq
        {K_WR,  4'd7, 8'hB0, 32'h02, 32'h0},       // R7 clear host err
        {K_RD,  4'd7, 8'hB0, 32'h0, 32'h0},        // R7 cleared
        {K_IRQ, 4'd5, 8'h00, 32'h0, 32'h0},        // R5 irq low
        {K_WR,  4'd8, 8'h88, 32'hFFFFFFFF, 32'h0}, // R8 set all tx
        {K_RD,  4'd8, 8'h88, 32'h0, 32'hFF},       // R8 high bits zero
        {K_WR,  4'd8, 8'h44, 32'hFFFFFFFF, 32'h0}, // R8 unmapped write
        {K_RD,  4'd8, 8'h44, 32'h0, 32'h0},        // R8 unmapped read
        {K_RD,  4'd3, 8'hA0, 32'h0, 32'h80},       // R3 rx still held
        {K_RXA, 4'd3, 8'h00, 32'h80, 32'h0},       // R3 ack rx ch7
        {K_RD,  4'd3, 8'hA0, 32'h0, 32'h0}         // R3 rx cleared
    };

    task automatic check(input int req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL R%0d actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        wr_en = 1'b0; wdata = '0; tx_done = '0; rx_done = '0;
        tx_ack = '0; rx_ack = '0; host_err = 1'b0;
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_run++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            idle_inputs();
            addr = VEC[i][71:64];
            case (VEC[i][78:76])
                K_WR:  begin wr_en = 1'b1; wdata = VEC[i][63:32]; end
                K_TXD: tx_done = VEC[i][32+NCH-1:32];
                K_RXD: rx_done = VEC[i][32+NCH-1:32];
                K_TXA: tx_ack  = VEC[i][32+NCH-1:32];
                K_RXA: rx_ack  = VEC[i][32+NCH-1:32];
                K_HE:  host_err = 1'b1;
                K_RD:  begin #1 check(int'(VEC[i][75:72]), rdata, VEC[i][31:0]); end
                K_IRQ: begin #1 check(int'(VEC[i][75:72]), {31'b0, irq}, VEC[i][31:0]); end
                default: ;
            endcase
        end
        // R3 directed: event and acknowledge on tx ch1 in the same cycle
        @(negedge clk); idle_inputs(); tx_done = 8'h02;
        @(negedge clk); idle_inputs(); tx_done = 8'h02; tx_ack = 8'h02;
        @(negedge clk); idle_inputs(); addr = 8'h80;
        #1 check(3, rdata & 32'h2, 32'h2);
        // R6 directed: EOI with nothing enabled keeps irq low
        @(negedge clk); idle_inputs(); wr_en = 1'b1; addr = 8'h8C; wdata = 32'hFF;
        @(negedge clk); idle_inputs(); wr_en = 1'b1; addr = 8'h94;
        @(negedge clk); idle_inputs();
        @(negedge clk); #1 check(6, {31'b0, irq}, 32'h0);
        // R1 directed: reset mid-run after making irq pending
        @(negedge clk); idle_inputs(); wr_en = 1'b1; addr = 8'h88; wdata = 32'h01;
        @(negedge clk); idle_inputs();
        @(negedge clk); #1 check(5, {31'b0, irq}, 32'h1);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1; addr = 8'h80;
        #1 check(1, rdata, 32'h0);
        addr = 8'h88;
        #1 check(1, rdata, 32'h0);
        check(1, {31'b0, irq}, 32'h0);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule